// File: doc/BRIEF.md
# I2C Target Controller with Selectable Clock Stretch

This block is a byte-level I2C target. It watches oversampled SCL and SDA lines and drives active-high pull-down enables for each line. It detects start and stop conditions and moves every byte in and out of one shift register. It checks the first byte after a start against a programmable 7-bit own address and also recognises extension codes.

After each byte it holds SCL low until a host acts. For data bytes, a configuration input picks whether that hold begins after the 8th or the 9th SCL falling edge. For the address byte, the match result sets the hold point instead. A single interrupt pulse tells the host when to act. The host ends a hold either by writing a byte into the shift register or by pulsing a release input.

While transmitting, the shift register samples the bus at every bit. At the end of the byte the block compares the sampled value with the byte the host loaded and reports any difference as a transmit error.

Top module: `i2c_tgt_wait`

## Requirements
- R1: After reset, scl_lo, sda_lo, irq, ext_code and tx_err are 0 and the target ignores the bus until a start condition.
- R2: A start (SDA falling while SCL is high) and a stop (SDA rising while SCL is high) are detected after a two-flop synchroniser. A stop pulses irq only when stop_ie is 1.
- R3: When the upper 7 bits of the first byte equal own_addr, the target drives ACK (SDA low) during the 9th clock without host action. It then holds SCL low and pulses irq after the 9th falling edge, whatever the value of wait9. tx_mode takes bit 0 of that byte, where 1 means the target transmits.
- R4: A first byte that does not match own_addr but has an upper nibble of 0000 or 1111 sets ext_code. It holds SCL and pulses irq after the 8th falling edge, whatever the value of wait9. ack_en at release picks ACK (1) or NACK (0) for the 9th clock, and no second hold follows.
- R5: Any other first byte gets no ACK, no irq and no hold, and the target ignores the bus until the next start.
- R6: With wait9=1, a received data byte is ACKed per ack_en during the 9th clock. The hold and irq follow the 9th falling edge, and rd_data shows the byte assembled MSB first.
- R7: With wait9=0, a received data byte raises the hold and irq after the 8th falling edge. The ack_en value present at release is driven during the 9th clock.
- R8: A one-cycle pulse on wr_en or rel ends a hold. wr_en also loads wr_data into the shift register.
- R9: In transmit mode, the byte the host wrote is sent MSB first. sda_lo changes only while SCL is low.
- R10: At the 8th falling edge of every transmitted byte, tx_err becomes 1 if the byte sampled from the bus differs from the byte loaded, and 0 otherwise. A start clears it.
- R11: A NACK from the controller after a transmitted byte makes the target release both lines and go idle, with no hold and no irq.
- R12: A repeated start during any byte aborts that byte, clears ext_code and restarts address reception.
- R13: irq is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_lo | output | 1 | Pull SCL low (clock stretch) |
| sda_lo | output | 1 | Pull SDA low |
| own_addr | input | 7 | Own target address |
| wait9 | input | 1 | Data-byte hold point: 0 = after 8th fall, 1 = after 9th fall |
| stop_ie | input | 1 | Enable irq on stop |
| ack_en | input | 1 | 1 = ACK, 0 = NACK for received bytes |
| wr_en | input | 1 | Load wr_data into shift register and release hold |
| wr_data | input | 8 | Byte to transmit |
| rel | input | 1 | Release hold without loading |
| rd_data | output | 8 | Shift register contents |
| irq | output | 1 | Interrupt pulse |
| ext_code | output | 1 | Extension code received |
| tx_err | output | 1 | Last transmitted byte differed on the bus |
| tx_mode | output | 1 | Target transmits data bytes |

## Verification
The bench checks the SCL hold point for address and data bytes under both wait9 settings. A design that let wait9 steer the address byte would stretch at the wrong edge, and the controller model would see a missing or misplaced ACK. It drives an ACK choice through a release in 8-clock mode, clocks a foreign address, and then tries to make the ignored target answer. It sends an extension code and a repeated start in the middle of a byte. In transmit mode it forces a bit low, which a design without bus read-back would miss. It then sends a NACK, which a design without the idle path would answer by stretching again.

// File: rtl/i2c_tgt_wait.sv
module i2c_tgt_wait (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_lo,
  output logic       sda_lo,
  input  logic [6:0] own_addr,
  input  logic       wait9,
  input  logic       stop_ie,
  input  logic       ack_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rel,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       ext_code,
  output logic       tx_err,
  output logic       tx_mode
);
  logic [2:0] scl_m, sda_m;
  logic [3:0] cnt;
  logic [7:0] sr, txb;
  logic active, addr_ph, hold, drv, ackbit, ext_r, err_r, tx_r, irq_r;

  wire scl_rise = scl_m[1] & ~scl_m[2];
  wire scl_fall = ~scl_m[1] & scl_m[2];
  wire start_c  = scl_m[1] & scl_m[2] & sda_m[2] & ~sda_m[1];
  wire stop_c   = scl_m[1] & scl_m[2] & ~sda_m[2] & sda_m[1];
  wire hit      = (sr[7:1] == own_addr);
  wire ext_c    = (sr[7:4] == 4'h0) || (sr[7:4] == 4'hF);
  wire txdata   = active & tx_r & ~addr_ph;
  wire release_w = wr_en | rel;

  assign scl_lo   = hold;
  assign sda_lo   = drv;
  assign rd_data  = sr;
  assign irq      = irq_r;
  assign ext_code = ext_r;
  assign tx_err   = err_r;
  assign tx_mode  = tx_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 3'b111; sda_m <= 3'b111;
      cnt <= 4'd0; sr <= 8'h00; txb <= 8'h00;
      active <= 1'b0; addr_ph <= 1'b0; hold <= 1'b0; drv <= 1'b0;
      ackbit <= 1'b1; ext_r <= 1'b0; err_r <= 1'b0; tx_r <= 1'b0; irq_r <= 1'b0;
    end else begin
      scl_m <= {scl_m[1:0], scl_i};
      sda_m <= {sda_m[1:0], sda_i};
      irq_r <= 1'b0;
      if (wr_en) begin
        sr  <= wr_data;
        txb <= wr_data;
        if (hold && txdata && cnt == 4'd0) drv <= ~wr_data[7];
      end
      if (release_w) begin
        hold <= 1'b0;
        if (hold && active && !txdata && cnt == 4'd8) drv <= ack_en;
      end
      if (start_c) begin
        active <= 1'b1; addr_ph <= 1'b1; cnt <= 4'd0; hold <= 1'b0; drv <= 1'b0;
        ext_r <= 1'b0; err_r <= 1'b0; tx_r <= 1'b0;
      end else if (stop_c) begin
        active <= 1'b0; hold <= 1'b0; drv <= 1'b0; irq_r <= stop_ie;
      end else if (active && scl_rise) begin
        if (cnt < 4'd8) sr <= {sr[6:0], sda_m[1]};
        else            ackbit <= sda_m[1];
        cnt <= cnt + 4'd1;
      end else if (active && scl_fall && cnt == 4'd8) begin
        if (addr_ph) begin
          tx_r <= sr[0];
          if (hit) drv <= 1'b1;
          else if (ext_c) begin ext_r <= 1'b1; hold <= 1'b1; irq_r <= 1'b1; end
          else active <= 1'b0;
        end else if (tx_r) begin
          err_r <= (sr != txb);
          drv   <= 1'b0;
          if (!wait9) begin hold <= 1'b1; irq_r <= 1'b1; end
        end else if (wait9) begin
          drv <= ack_en;
        end else begin
          hold <= 1'b1; irq_r <= 1'b1;
        end
      end else if (active && scl_fall && cnt == 4'd9) begin
        cnt <= 4'd0; addr_ph <= 1'b0;
        if (addr_ph) begin
          drv <= 1'b0;
          if (!ext_r) begin hold <= 1'b1; irq_r <= 1'b1; end
        end else if (tx_r && ackbit) begin
          active <= 1'b0; drv <= 1'b0;
        end else begin
          drv <= tx_r & ~sr[7];
          if (wait9) begin hold <= 1'b1; irq_r <= 1'b1; end
        end
      end else if (scl_fall && txdata && cnt < 4'd8) begin
        drv <= ~sr[7];
      end
    end
  end
endmodule

module i2c_tgt_wait_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_lo,
  input logic sda_lo,
  input logic irq,
  input logic ext_code,
  input logic tx_err,
  input logic tx_mode,
  input logic active,
  input logic scl_s
);
  a_r13_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!sda_lo && !scl_lo));
  a_r9_sda_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_lo) |-> !$past(scl_s));
  a_r8_hold_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_lo) |-> !$past(scl_s));
  a_r4_ext_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_code) |-> scl_lo);
  a_r10_err_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_err) |-> tx_mode);
endmodule

bind i2c_tgt_wait i2c_tgt_wait_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lo(scl_lo), .sda_lo(sda_lo), .irq(irq),
  .ext_code(ext_code), .tx_err(tx_err), .tx_mode(tx_mode), .active(active),
  .scl_s(scl_m[1])
);

// File: tb/i2c_tgt_wait_bench.sv
`timescale 1ns/1ps
module i2c_tgt_wait_bench;
  localparam int H = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] own_addr = 7'h2A;
  logic wait9 = 1'b1, stop_ie = 1'b1, ack_en = 1'b1, wr_en = 1'b0, rel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic scl_lo, sda_lo, irq, ext_code, tx_err, tx_mode;
  logic [7:0] rd_data;
  wire scl_bus = m_scl & ~scl_lo;
  wire sda_bus = m_sda & ~sda_lo;
  int errors = 0, checks = 0, irq_n = 0, n = 0;
  bit done = 1'b0, prev_irq = 1'b0, pulse_bad = 1'b0, prev_scl = 1'b1, prev_sda_lo = 1'b0;
  bit a;
  logic [7:0] g;

  always #2 clk = ~clk;

  i2c_tgt_wait u_i2c_tgt_wait (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .scl_lo(scl_lo),
    .sda_lo(sda_lo), .own_addr(own_addr), .wait9(wait9), .stop_ie(stop_ie),
    .ack_en(ack_en), .wr_en(wr_en), .wr_data(wr_data), .rel(rel), .rd_data(rd_data),
    .irq(irq), .ext_code(ext_code), .tx_err(tx_err), .tx_mode(tx_mode));

  always @(posedge clk) begin
    if (rst_n && irq) irq_n <= irq_n + 1;
    if (rst_n && irq && prev_irq) pulse_bad <= 1'b1;
    prev_irq <= irq;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && prev_scl && scl_bus && (sda_lo != prev_sda_lo))
      chk("R9 sda_lo moved while SCL high", 1, 0);
    prev_scl <= scl_bus;
    prev_sda_lo <= sda_lo;
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda = 1'b1; cyc(H); m_scl = 1'b1; cyc(H); m_sda = 1'b0; cyc(H); m_scl = 1'b0; cyc(H);
  endtask

  task automatic m_stop;
    m_sda = 1'b0; cyc(H); m_scl = 1'b1; cyc(H); m_sda = 1'b1; cyc(H);
  endtask

  task automatic m_bit(input bit b, output bit got);
    int t;
    m_sda = b; cyc(H); m_scl = 1'b1;
    t = 0;
    while (!scl_bus && t < 3000) begin cyc(1); t++; end
    if (t >= 3000) chk("R8 SCL hold never released", 1, 0);
    cyc(H); got = sda_bus; m_scl = 1'b0; cyc(H);
  endtask

  task automatic m_byte(input logic [7:0] v, output logic [7:0] got);
    bit s;
    for (int i = 7; i >= 0; i--) begin m_bit(v[i], s); got[i] = s; end
  endtask

  task automatic host_rel;
    rel = 1'b1; cyc(1); rel = 1'b0; cyc(4);
  endtask

  task automatic host_wr(input logic [7:0] v);
    wr_data = v; wr_en = 1'b1; cyc(1); wr_en = 1'b0; cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk("watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(10); rst_n = 1'b1; cyc(5);
    chk("R1 scl_lo", scl_lo, 0); chk("R1 sda_lo", sda_lo, 0); chk("R1 irq", irq, 0);
    chk("R1 ext_code", ext_code, 0); chk("R1 tx_err", tx_err, 0);

    // R3 address match, R6 wait after 9th
    m_start; n = irq_n;
    m_byte(8'h54, g); chk("R3 no hold at 8th", scl_lo, 0);
    m_bit(1'b1, a); chk("R3 auto ACK", a, 0); chk("R3 hold after 9th", scl_lo, 1);
    chk("R3 irq", irq_n, n + 1); chk("R3 tx_mode write", tx_mode, 0);
    host_rel; chk("R8 rel ends hold", scl_lo, 0);
    n = irq_n; m_byte(8'hA5, g); chk("R6 no hold at 8th", scl_lo, 0);
    m_bit(1'b1, a); chk("R6 ACK", a, 0); chk("R6 hold", scl_lo, 1);
    chk("R6 irq", irq_n, n + 1); chk("R6 rd_data", rd_data, 8'hA5);
    host_rel;

    // R7 wait after 8th, NACK chosen before release
    wait9 = 1'b0; n = irq_n;
    m_byte(8'h3C, g); chk("R7 hold at 8th", scl_lo, 1); chk("R7 irq", irq_n, n + 1);
    chk("R7 rd_data", rd_data, 8'h3C);
    ack_en = 1'b0; host_rel;
    m_bit(1'b1, a); chk("R7 NACK driven", a, 1); chk("R7 no hold at 9th", scl_lo, 0);
    n = irq_n; m_stop; cyc(10); chk("R2 stop irq enabled", irq_n, n + 1);

    // R5 address mismatch
    ack_en = 1'b1; stop_ie = 1'b0; wait9 = 1'b1;
    m_start; n = irq_n;
    m_byte(8'h22, g); chk("R5 no hold", scl_lo, 0);
    m_bit(1'b1, a); chk("R5 no ACK", a, 1); chk("R5 no hold 9th", scl_lo, 0);
    m_byte(8'h00, g); m_bit(1'b1, a); chk("R5 data ignored", a, 1);
    chk("R5 no irq", irq_n, n);
    m_stop; cyc(10); chk("R2 stop irq disabled", irq_n, n);

    // R4 extension code ignores wait9
    m_start; n = irq_n;
    m_byte(8'hF0, g); chk("R4 hold at 8th", scl_lo, 1); chk("R4 ext_code", ext_code, 1);
    chk("R4 irq", irq_n, n + 1);
    host_rel; m_bit(1'b1, a); chk("R4 ACK from ack_en", a, 0);
    chk("R4 no second hold", scl_lo, 0);

    // R12 repeated start mid-byte
    m_bit(1'b1, a); m_bit(1'b0, a); m_bit(1'b1, a);
    m_start; chk("R12 ext_code cleared", ext_code, 0); n = irq_n;
    m_byte(8'h55, g); m_bit(1'b1, a); chk("R12 address ACK", a, 0);
    chk("R12 hold", scl_lo, 1); chk("R12 irq", irq_n, n + 1); chk("R3 tx_mode read", tx_mode, 1);

    // R9 transmit, R10 error, R11 NACK
    host_wr(8'hC3); chk("R8 wr_en ends hold", scl_lo, 0);
    m_byte(8'hFF, g); chk("R9 byte sent", g, 8'hC3); chk("R10 no error", tx_err, 0);
    chk("R9 no hold at 8th", scl_lo, 0);
    n = irq_n; m_bit(1'b0, a); chk("R9 hold after ACK", scl_lo, 1); chk("R9 irq", irq_n, n + 1);
    host_wr(8'h81);
    m_byte(8'h7F, g); chk("R10 bus value", g, 8'h01); chk("R10 error flagged", tx_err, 1);
    n = irq_n; m_bit(1'b1, a);
    chk("R11 no hold", scl_lo, 0); chk("R11 no irq", irq_n, n); chk("R11 sda released", sda_lo, 0);
    m_byte(8'hFF, g); chk("R11 idle after NACK", g, 8'hFF);
    m_stop; cyc(10);

    chk("R13 irq single cycle", pulse_bad, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule